// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control

This block holds the status and control word of one downstream port of a USB host controller root hub. The host driver writes the word over a simple register bus and reads it back through a combinational read port. The block also watches the device-present and overcurrent inputs of the port.

Writing a 1 to a request bit starts an action, and writing a 0 has no effect. A port reset and a resume each run for a fixed number of clock cycles, counted by internal timers. When an action ends, the block clears its active bit and sets a change flag in the same cycle. A request made to a port with no device attached does not start anything. It sets the connect-change flag instead, so that the driver learns the port is empty. A multi-port root hub uses one instance for each port.

Top module: `hub_port_ctl`

## Requirements
- R1: After reset, `rd_data_o` reads 0, and `change_o`, `port_reset_o` and `port_resume_o` are 0.
- R2: Bit 4 of the word is the reset-active bit. On a connected port (bit 0 set), a write with bit 4 = 1 sets bit 4 at the next clock edge. A write with bit 4 = 0 never sets it, and bit 4 never rises without such a write.
- R3: On a disconnected port, a write with bit 4 = 1 or bit 2 = 1 leaves bits 4 and 2 clear and sets the connect-change flag (bit 16).
- R4: The reset-active bit and `port_reset_o` stay high for exactly RESET_CYCLES cycles. At the edge where they clear, the reset-change flag (bit 20) sets and the suspended bit (bit 2) clears.
- R5: Bit 3 reads `overcurrent_i` when OC_PER_PORT = 1, and reads 0 when OC_PER_PORT = 0.
- R6: Bit 2 is the suspended bit. On a connected port, a write with bit 2 = 1 sets it at the next edge.
- R7: A write with bit 3 = 1 is ignored while bit 2 is clear. While bit 2 is set, the same write starts a resume. `port_resume_o` is then high for RESUME_CYCLES cycles and bit 2 stays set during that time. At the end, bit 2 clears and the suspend-change flag (bit 18) sets in the same edge.
- R8: While `global_resume_i` is high, bit 2 clears and any running resume is abandoned without setting bit 18.
- R9: Writing 1 to bit 16, 18 or 20 clears that flag. If a flag is set and cleared in the same cycle, the set wins. `change_o` is the OR of the three flags.
- R10: Bit 0 follows `connect_i` one cycle later, and every change of `connect_i` sets bit 16. A disconnect stops a running reset or resume and clears bits 4 and 2, without setting bit 18 or bit 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the status word |
| wr_data_i | input | 32 | Write data: request bits and write-1-to-clear flags |
| rd_data_o | output | 32 | Current status word |
| connect_i | input | 1 | Device present on the port |
| overcurrent_i | input | 1 | Overcurrent detected on this port |
| global_resume_i | input | 1 | Host controller is in its global resume state |
| port_reset_o | output | 1 | Drive reset signalling on the port |
| port_resume_o | output | 1 | Drive resume signalling on the port |
| change_o | output | 1 | At least one change flag is set |

## Verification
The bench builds the block with RESET_CYCLES = 6 and RESUME_CYCLES = 9. With these values, the full reset and resume sequences, including the exact cycle at which each one ends, fit into a few dozen cycles instead of millions. A second instance built with OC_PER_PORT = 0 runs beside the first. It shows that the overcurrent bit is masked while the same input is high on the first instance.

// File: rtl/hub_port_pkg.sv
package hub_port_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned B_CCS  = 0;
  localparam int unsigned B_PSS  = 2;
  localparam int unsigned B_POCI = 3;
  localparam int unsigned B_PRS  = 4;
  localparam int unsigned B_CSC  = 16;
  localparam int unsigned B_PSSC = 18;
  localparam int unsigned B_PRSC = 20;
  localparam int unsigned NFLAG  = 3;
  // flag index -> bit position
  function automatic int unsigned flag_bit(int unsigned idx);
    case (idx)
      0:       return B_CSC;
      1:       return B_PSSC;
      default: return B_PRSC;
    endcase
  endfunction
endpackage

// File: rtl/hub_port_timer.sv
module hub_port_timer #(
  parameter int unsigned CYCLES = 1000,
  localparam int unsigned CW = $clog2(CYCLES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic busy_o,
  output logic done_o
);
  logic [CW-1:0] cnt_q;
  logic          busy_q;

  assign done_o = busy_q && (cnt_q == '0);
  assign busy_o = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (abort_i || done_o) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CW'(CYCLES - 1);
    end else if (busy_q) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hub_port_flag.sv
module hub_port_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set beats clear
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/hub_port_ctl.sv
module hub_port_ctl
  import hub_port_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned RESET_CYCLES  = CLK_HZ / 100,
  parameter int unsigned RESUME_CYCLES = CLK_HZ / 50,
  parameter bit          OC_PER_PORT   = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          connect_i,
  input  logic          overcurrent_i,
  input  logic          global_resume_i,
  output logic          port_reset_o,
  output logic          port_resume_o,
  output logic          change_o
);
  logic ccs_q, pss_q;
  logic conn_edge, drop;
  logic wr_rst, wr_sus, wr_res;
  logic rst_start, rst_busy, rst_done;
  logic res_start, res_abort, res_busy, res_done;
  logic [NFLAG-1:0] flag_set, flag_clr, flag_q;
  logic unused_wr;

  assign unused_wr = ^{wr_data_i[31:21], wr_data_i[19], wr_data_i[17],
                       wr_data_i[15:5], wr_data_i[1:0]};

  assign conn_edge = ccs_q ^ connect_i;
  assign drop      = ccs_q & ~connect_i;

  assign wr_rst = wr_en_i & wr_data_i[B_PRS];
  assign wr_sus = wr_en_i & wr_data_i[B_PSS];
  assign wr_res = wr_en_i & wr_data_i[B_POCI];

  assign rst_start = wr_rst & ccs_q & ~drop;
  assign res_start = wr_res & pss_q & ~rst_busy & ~drop & ~global_resume_i;
  assign res_abort = drop | global_resume_i | rst_done;

  hub_port_timer #(.CYCLES(RESET_CYCLES)) u_rst_tmr (
    .clk_i, .rst_ni, .start_i(rst_start), .abort_i(drop),
    .busy_o(rst_busy), .done_o(rst_done)
  );

  hub_port_timer #(.CYCLES(RESUME_CYCLES)) u_res_tmr (
    .clk_i, .rst_ni, .start_i(res_start), .abort_i(res_abort),
    .busy_o(res_busy), .done_o(res_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ccs_q <= 1'b0;
      pss_q <= 1'b0;
    end else begin
      ccs_q <= connect_i;
      if (drop || rst_done || global_resume_i || res_done) pss_q <= 1'b0;
      else if (wr_sus && ccs_q)                           pss_q <= 1'b1;
    end
  end

  // flag 0: connect change, 1: suspend change, 2: reset change
  assign flag_set[0] = conn_edge | ((wr_rst | wr_sus) & ~ccs_q);
  assign flag_set[1] = res_done & ~res_abort;
  assign flag_set[2] = rst_done & ~drop;

  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    assign flag_clr[g] = wr_en_i & wr_data_i[flag_bit(g)];
    hub_port_flag u_flag (
      .clk_i, .rst_ni, .set_i(flag_set[g]), .clr_i(flag_clr[g]), .q_o(flag_q[g])
    );
  end

  always_comb begin
    rd_data_o                 = '0;
    rd_data_o[B_CCS]          = ccs_q;
    rd_data_o[B_PSS]          = pss_q;
    rd_data_o[B_POCI]         = OC_PER_PORT & overcurrent_i;
    rd_data_o[B_PRS]          = rst_busy;
    for (int i = 0; i < NFLAG; i++) rd_data_o[flag_bit(i)] = flag_q[i];
  end

  assign port_reset_o  = rst_busy;
  assign port_resume_o = res_busy;
  assign change_o      = |flag_q;
endmodule

// File: rtl/hub_port_chk.sv
module hub_port_chk #(
  parameter bit OC_PER_PORT = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_en_i,
  input logic wr_rst_bit_i,
  input logic overcurrent_i,
  input logic ccs_i,
  input logic pss_i,
  input logic poci_i,
  input logic prs_i,
  input logic prsc_i
);
  // R2
  prs_needs_conn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prs_i |-> ccs_i);

  // R6
  pss_needs_conn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pss_i |-> ccs_i);

  // R2
  prs_rise_by_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(prs_i) |-> $past(wr_en_i && wr_rst_bit_i));

  // R4
  prs_end_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(prs_i) && ccs_i) |-> prsc_i);

  // R5
  oc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    poci_i == (OC_PER_PORT && overcurrent_i));
endmodule

bind hub_port_ctl hub_port_chk #(.OC_PER_PORT(OC_PER_PORT)) chk_i (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .wr_en_i(wr_en_i),
  .wr_rst_bit_i(wr_data_i[4]),
  .overcurrent_i(overcurrent_i),
  .ccs_i(rd_data_o[0]),
  .pss_i(rd_data_o[2]),
  .poci_i(rd_data_o[3]),
  .prs_i(rd_data_o[4]),
  .prsc_i(rd_data_o[20])
);

// File: tb/hub_port_ctl_tb_top.sv
module hub_port_ctl_tb_top;
  localparam int unsigned RST_N = 6;
  localparam int unsigned RES_N = 9;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        conn = 1'b0, oc = 1'b0, gres = 1'b0;
  logic [31:0] rd, rd2;
  logic        prst, pres, chg, prst2, pres2, chg2;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  hub_port_ctl #(.RESET_CYCLES(RST_N), .RESUME_CYCLES(RES_N), .OC_PER_PORT(1'b1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd),
    .connect_i(conn), .overcurrent_i(oc), .global_resume_i(gres),
    .port_reset_o(prst), .port_resume_o(pres), .change_o(chg));

  hub_port_ctl #(.RESET_CYCLES(RST_N), .RESUME_CYCLES(RES_N), .OC_PER_PORT(1'b0)) dut_oc_off_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd2),
    .connect_i(conn), .overcurrent_i(oc), .global_resume_i(gres),
    .port_reset_o(prst2), .port_resume_o(pres2), .change_o(chg2));

  // {connect, write, wdata, expected word}
  localparam logic [65:0] VEC [9] = '{
    {1'b0, 1'b0, 32'h0000_0000, 32'h0000_0000},  // R1 idle
    {1'b0, 1'b1, 32'h0000_0010, 32'h0001_0000},  // R3 reset on empty port
    {1'b0, 1'b1, 32'h0000_0004, 32'h0001_0000},  // R3 suspend on empty port
    {1'b0, 1'b1, 32'h0001_0000, 32'h0000_0000},  // R9 clear connect change
    {1'b1, 1'b0, 32'h0000_0000, 32'h0001_0001},  // R10 attach
    {1'b1, 1'b1, 32'h0001_0000, 32'h0000_0001},  // R9 clear
    {1'b1, 1'b1, 32'h0000_0008, 32'h0000_0001},  // R7 resume ignored
    {1'b1, 1'b1, 32'h0000_0004, 32'h0000_0005},  // R6 suspend
    {1'b1, 1'b1, 32'h0000_0000, 32'h0000_0005}   // R2 zero write no effect
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    tick();
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word", rd, 32'h0);
    check("R1 outputs", {29'h0, chg, prst, pres}, 32'h0);

    for (int i = 0; i < 9; i++) begin
      conn = VEC[i][65];
      wr_en = VEC[i][64];
      wr_data = VEC[i][63:32];
      tick();
      wr_en = 1'b0;
      wr_data = '0;
      check($sformatf("R2/R3/R6/R7/R9/R10 vector %0d", i), rd, VEC[i][31:0]);
    end

    // R7 resume sequence
    wr(32'h8);
    check("R7 resume start", {30'h0, pres, rd[2]}, 32'h3);
    repeat (RES_N - 1) tick();
    check("R7 resume last cycle", {30'h0, pres, rd[2]}, 32'h3);
    tick();
    check("R7 resume end", rd, 32'h0004_0001);
    check("R9 change out", {31'h0, chg}, 32'h1);
    wr(32'h0004_0000);
    check("R9 clear suspend change", {31'h0, chg}, 32'h0);

    // R4 reset also clears suspend
    wr(32'h4);
    wr(32'h10);
    check("R4 reset start", {27'h0, rd[4], 3'h0, prst}, 32'h11);
    repeat (RST_N - 1) tick();
    check("R4 reset last cycle", {27'h0, rd[4], 3'h0, prst}, 32'h11);
    tick();
    check("R4 reset end", rd, 32'h0010_0001);
    wr(32'h0010_0000);
    check("R9 clear reset change", rd, 32'h1);

    // R8 global resume
    wr(32'h4);
    wr(32'h8);
    tick();
    gres = 1'b1;
    tick();
    gres = 1'b0;
    check("R8 global resume", {rd[18], rd[2], pres}, 3'b000);
    repeat (RES_N) tick();
    check("R8 no suspend change", rd, 32'h1);

    // R10 disconnect during reset
    wr(32'h10);
    tick();
    conn = 1'b0;
    tick();
    check("R10 abort reset", rd, 32'h0001_0000);
    check("R10 reset out low", {31'h0, prst}, 32'h0);
    repeat (RST_N) tick();
    check("R10 no reset change", rd, 32'h0001_0000);

    // R9 set wins over clear
    conn = 1'b1;
    wr(32'h0001_0000);
    check("R9 set wins", rd, 32'h0001_0001);

    // R5 overcurrent
    oc = 1'b1;
    #1;
    check("R5 oc enabled", {31'h0, rd[3]}, 32'h1);
    check("R5 oc disabled", {31'h0, rd2[3]}, 32'h0);
    oc = 1'b0;
    #1;
    check("R5 oc released", {31'h0, rd[3]}, 32'h0);

    finish_run();
  end
endmodule